// File: doc/BRIEF.md
# Static Memory Bank Timing Sequencer

This block sits between an on-chip request port and an asynchronous external bus that carries static memories or memory-mapped peripherals on four chip-select lines. The two most significant request address bits pick a bank, and the rest is an offset inside that bank's 128 KiB window. Every bank holds its own timing set. That set has six cycle counts, plus a data-width bit and a page-mode bit. The sequencer reads the chosen bank's settings when it accepts a request. It then steps the external strobes through five phases in order: address setup, chip-select lead, strobe/access, chip-select hold and address hold.

A read can run as a four-beat page burst. Chip select and output enable stay low across the whole burst, and only the two lowest external address bits move. For a write, the write strobe takes the place of the output enable and uses the same timing, while the data bus is driven. The caller sees one response pulse once the address-hold phase has ended. The response carries up to four read beats.

Top module: `static_bank_seq`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1, every `mem_csn` bit is 1, `mem_oen` and `mem_wen` are 1, and `mem_doe` and `rsp_valid` are 0.
- R2: The bank is `req_addr[18:17]`. During a transfer, only `mem_csn[bank]` goes low, and no two chip selects are ever low together.
- R3: The external address appears in the cycle after acceptance. The chip select goes low `acs` cycles later. A count of 0 skips the phase.
- R4: The strobe (`mem_oen` for reads) goes low `cos` cycles after the chip select does. In a single access it stays low for `acc`+1 cycles.
- R5: The chip select stays low for `coh` cycles after the strobe rises, and the address is held `cah` cycles after the chip select rises. `rsp_valid` pulses for one cycle in the cycle after that, and `req_ready` returns to 1 in that same cycle.
- R6: The external address depends on the bank width. A byte-wide bank (`wide`=0) puts the offset on `mem_addr` and returns `mem_din[7:0]` zero-extended. A halfword bank (`wide`=1) puts offset>>1 on `mem_addr` and returns all 16 bits.
- R7: On a read with `page`=1, four beats run under one chip select and one strobe. Beat k uses the address with its two lowest bits equal to (base+k) mod 4. Beat 0 lasts `acc`+1 cycles and each later beat lasts `acp`+1 cycles. Beat k is returned in `rsp_rdata[16k+15:16k]`. Unused beats read as 0.
- R8: On a write, `mem_wen` follows the read strobe timing and `mem_oen` stays high. `mem_doe` is high from the first write-strobe cycle through the end of the chip-select hold. `mem_dout` is the write data, with the upper byte 0 for byte-wide banks. `page` has no effect on writes.
- R9: Configuration words are written per bank through `cfg_wr`/`cfg_sel`/`cfg_word`. The bit fields are `acs`[3:0], `cos`[7:4], `acc`[12:8], `coh`[16:13], `cah`[20:17], `acp`[24:21], `wide`[25] and `page`[26]. After reset, all fields are 0. Writing one bank leaves the others unchanged.
- R10: `req_ready` is 0 from the cycle after acceptance until the response cycle, so no second request is taken while a transfer is in flight.
- R11: `mem_oen` and `mem_wen` are never both low, and neither goes low unless a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write enable for the bank configuration |
| cfg_sel | input | 2 | Bank whose configuration is written |
| cfg_word | input | 27 | Packed timing, width and page settings |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; request taken when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Bank number (top 2 bits) and byte offset |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Read beats, beat k in bits 16k+15:16k |
| mem_csn | output | 4 | Active-low chip selects, one per bank |
| mem_oen | output | 1 | Active-low output enable |
| mem_wen | output | 1 | Active-low write enable |
| mem_addr | output | 17 | External address |
| mem_dout | output | 16 | External write data |
| mem_doe | output | 1 | Data bus drive enable |
| mem_din | input | 16 | External read data |

## Verification
The bench targets zero-length phases. A design that fails to skip a zero-length phase would add a cycle to every access on a default-configured bank, or would assert the chip select late. The page burst starts at a base whose low bits are 3, so the beat address has to wrap. A sequencer that carries into bit 2 or re-asserts the chip select between beats shows a wrong address or a wrong strobe count. Writes are run with the page bit set and with the largest access count. This exposes a write that bursts, a drive window that ends with the strobe instead of the hold, and an access counter that is too narrow. After the other banks are reprogrammed, a default bank is run again to catch configuration bleeding between banks.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // Per-bank settings; field positions are part of the configuration word
  typedef struct packed {
    logic       page;
    logic       wide;
    logic [3:0] acp;
    logic [3:0] cah;
    logic [3:0] coh;
    logic [4:0] acc;
    logic [3:0] cos;
    logic [3:0] acs;
  } bank_cfg_t;

  localparam int CFG_W = $bits(bank_cfg_t);

  typedef enum logic [2:0] {
    PH_IDLE, PH_ASU, PH_CSU, PH_ACC, PH_PAGE, PH_COH, PH_CAH
  } phase_e;

  // Cycles spent in a phase; zero means the phase is skipped
  function automatic logic [5:0] phase_len(phase_e ph, bank_cfg_t c);
    case (ph)
      PH_ASU:  return {2'b00, c.acs};
      PH_CSU:  return {2'b00, c.cos};
      PH_ACC:  return {1'b0, c.acc} + 6'd1;
      PH_PAGE: return {2'b00, c.acp} + 6'd1;
      PH_COH:  return {2'b00, c.coh};
      PH_CAH:  return {2'b00, c.cah};
      default: return 6'd1;
    endcase
  endfunction

  // Walk past empty phases; at most two skippable phases follow each other
  function automatic phase_e skip_empty(phase_e ph, bank_cfg_t c);
    phase_e p;
    p = ph;
    for (int i = 0; i < 2; i++) begin
      if (p != PH_IDLE && phase_len(p, c) == 6'd0) begin
        case (p)
          PH_ASU:  p = PH_CSU;
          PH_CSU:  p = PH_ACC;
          PH_COH:  p = PH_CAH;
          default: p = PH_IDLE;
        endcase
      end
    end
    return p;
  endfunction

endpackage

// File: rtl/sbs_cfg_regs.sv
module sbs_cfg_regs
  import sbs_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int SEL_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [SEL_W-1:0]      sel,
  input  bank_cfg_t             word,
  output bank_cfg_t [NBANK-1:0] cfg
);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                              cfg[b] <= '0;
      else if (wr && sel == SEL_W'(b))      cfg[b] <= word;
    end
  end

endmodule

// File: rtl/sbs_phase_seq.sv
module sbs_phase_seq
  import sbs_pkg::*;
#(
  parameter int BEATS  = 4,
  parameter int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              page_en,
  input  bank_cfg_t         cfg,
  output phase_e            ph_q,
  output phase_e            ph_d,
  output logic [BEAT_W-1:0] beat_q,
  output logic [BEAT_W-1:0] beat_d,
  output logic              sample,
  output logic              fin
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic [5:0] cnt_q, cnt_d;
  phase_e     nxt;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    beat_d = beat_q;
    sample = 1'b0;
    fin    = 1'b0;
    nxt    = PH_IDLE;
    if (ph_q == PH_IDLE) begin
      if (start) begin
        ph_d   = skip_empty(PH_ASU, cfg);
        cnt_d  = phase_len(ph_d, cfg) - 6'd1;
        beat_d = '0;
      end
    end else if (cnt_q != 6'd0) begin
      cnt_d = cnt_q - 6'd1;
    end else begin
      case (ph_q)
        PH_ASU: nxt = PH_CSU;
        PH_CSU: nxt = PH_ACC;
        PH_ACC, PH_PAGE: begin
          sample = 1'b1;
          if (page_en && beat_q != LAST_BEAT) begin
            nxt    = PH_PAGE;
            beat_d = beat_q + 1'b1;
          end else begin
            nxt = PH_COH;
          end
        end
        PH_COH:  nxt = PH_CAH;
        default: nxt = PH_IDLE;
      endcase
      ph_d  = skip_empty(nxt, cfg);
      cnt_d = phase_len(ph_d, cfg) - 6'd1;
      fin   = (ph_d == PH_IDLE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      beat_q <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      beat_q <= beat_d;
    end
  end

endmodule

// File: rtl/static_bank_seq.sv
module static_bank_seq
  import sbs_pkg::*;
#(
  parameter int NBANK   = 4,
  parameter int BANK_AW = 17,
  parameter int DATA_W  = 16,
  parameter int BEATS   = 4,
  parameter int SEL_W   = (NBANK > 1) ? $clog2(NBANK) : 1,
  parameter int ADDR_W  = SEL_W + BANK_AW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_wr,
  input  logic [SEL_W-1:0]        cfg_sel,
  input  logic [CFG_W-1:0]        cfg_word,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic [BEATS*DATA_W-1:0] rsp_rdata,
  output logic [NBANK-1:0]        mem_csn,
  output logic                    mem_oen,
  output logic                    mem_wen,
  output logic [BANK_AW-1:0]      mem_addr,
  output logic [DATA_W-1:0]       mem_dout,
  output logic                    mem_doe,
  input  logic [DATA_W-1:0]       mem_din
);

  localparam int BYTE_W = DATA_W / 2;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  bank_cfg_t [NBANK-1:0] cfg_all;
  bank_cfg_t             cfg_in;
  assign cfg_in = bank_cfg_t'(cfg_word);

  sbs_cfg_regs #(.NBANK(NBANK), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .sel(cfg_sel), .word(cfg_in), .cfg(cfg_all)
  );

  // Request decode and per-transfer context
  logic [SEL_W-1:0]   req_bank, act_bank_q, bank_now;
  logic [BANK_AW-1:0] req_off, req_base, base_q, base_now, addr_beat;
  bank_cfg_t          act_cfg_q, cfg_now;
  logic               act_wr_q, wr_now, idle, accept;

  assign req_bank  = req_addr[ADDR_W-1 -: SEL_W];
  assign req_off   = req_addr[BANK_AW-1:0];
  assign req_base  = cfg_all[req_bank].wide ? {1'b0, req_off[BANK_AW-1:1]} : req_off;

  phase_e            ph_q, ph_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              sample, fin;

  assign idle      = (ph_q == PH_IDLE);
  assign req_ready = idle;
  assign accept    = req_valid & idle;
  assign cfg_now   = idle ? cfg_all[req_bank] : act_cfg_q;
  assign wr_now    = idle ? req_write : act_wr_q;
  assign bank_now  = idle ? req_bank : act_bank_q;
  assign base_now  = idle ? req_base : base_q;
  assign addr_beat = {base_now[BANK_AW-1:BEAT_W], base_now[BEAT_W-1:0] + beat_d};

  sbs_phase_seq #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_seq (
    .clk(clk), .rst(rst), .start(accept), .page_en(cfg_now.page & ~wr_now),
    .cfg(cfg_now), .ph_q(ph_q), .ph_d(ph_d), .beat_q(beat_q), .beat_d(beat_d),
    .sample(sample), .fin(fin)
  );

  // Bus strobes decoded from the next phase, then registered
  logic cs_on, strobe_on, hold_on;
  assign cs_on     = ph_d inside {PH_CSU, PH_ACC, PH_PAGE, PH_COH};
  assign strobe_on = ph_d inside {PH_ACC, PH_PAGE};
  assign hold_on   = ph_d inside {PH_ACC, PH_COH};

  logic [BEATS-1:0][DATA_W-1:0] rbuf;
  assign rsp_rdata = rbuf;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_csn    <= '1;
      mem_oen    <= 1'b1;
      mem_wen    <= 1'b1;
      mem_doe    <= 1'b0;
      mem_addr   <= '0;
      mem_dout   <= '0;
      act_cfg_q  <= '0;
      act_wr_q   <= 1'b0;
      act_bank_q <= '0;
      base_q     <= '0;
      rbuf       <= '0;
      rsp_valid  <= 1'b0;
    end else begin
      mem_csn   <= cs_on ? ~({{(NBANK-1){1'b0}}, 1'b1} << bank_now) : '1;
      mem_oen   <= ~(strobe_on & ~wr_now);
      mem_wen   <= ~(strobe_on & wr_now);
      mem_doe   <= wr_now & hold_on;
      rsp_valid <= fin;
      if (ph_d != PH_IDLE) mem_addr <= addr_beat;
      if (accept) begin
        act_cfg_q  <= cfg_now;
        act_wr_q   <= req_write;
        act_bank_q <= req_bank;
        base_q     <= req_base;
        mem_dout   <= cfg_now.wide ? req_wdata : {{(DATA_W-BYTE_W){1'b0}}, req_wdata[BYTE_W-1:0]};
        rbuf       <= '0;
      end
      if (sample)
        rbuf[beat_q] <= act_cfg_q.wide ? mem_din : {{(DATA_W-BYTE_W){1'b0}}, mem_din[BYTE_W-1:0]};
    end
  end

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int NBANK   = 4,
  parameter int BANK_AW = 17,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic [NBANK-1:0]   mem_csn,
  input logic               mem_oen,
  input logic               mem_wen,
  input logic               mem_doe,
  input logic [BANK_AW-1:0] mem_addr,
  input logic [DATA_W-1:0]  mem_dout
);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(~mem_csn)); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) (mem_oen || mem_wen)); // R11
  AST_OE_UNDER_CS: assert property (@(posedge clk) disable iff (rst) !mem_oen |-> (mem_csn != '1)); // R11
  AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (rst) !mem_wen |-> (mem_csn != '1)); // R11
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (rst) req_ready |-> (&mem_csn && mem_oen && mem_wen && !mem_doe)); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> !req_ready); // R10
  AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst) !mem_wen |-> mem_doe); // R8
  AST_WE_BUS_STABLE: assert property (@(posedge clk) disable iff (rst) (!mem_wen && $past(!mem_wen)) |-> ($stable(mem_addr) && $stable(mem_dout))); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid); // R5

endmodule

bind static_bank_seq sbs_checker #(.NBANK(NBANK), .BANK_AW(BANK_AW), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_csn(mem_csn), .mem_oen(mem_oen), .mem_wen(mem_wen), .mem_doe(mem_doe),
  .mem_addr(mem_addr), .mem_dout(mem_dout)
);

// File: tb/static_bank_seq_bench.sv
module static_bank_seq_bench;
  import sbs_pkg::*;

  localparam int NB = 4, AW = 17, DW = 16, NBEAT = 4;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic                cfg_wr = 1'b0;
  logic [1:0]          cfg_sel = '0;
  logic [CFG_W-1:0]    cfg_word = '0;
  logic                req_valid = 1'b0, req_write = 1'b0;
  logic                req_ready, rsp_valid, mem_oen, mem_wen, mem_doe;
  logic [AW+1:0]       req_addr = '0;
  logic [DW-1:0]       req_wdata = '0, mem_dout, mem_din;
  logic [NBEAT*DW-1:0] rsp_rdata;
  logic [NB-1:0]       mem_csn;
  logic [AW-1:0]       mem_addr;

  static_bank_seq u_static_bank_seq (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_csn(mem_csn),
    .mem_oen(mem_oen), .mem_wen(mem_wen), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_doe(mem_doe), .mem_din(mem_din)
  );

  function automatic logic [DW-1:0] model(logic [AW-1:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] + 8'h11};
  endfunction
  assign mem_din = !mem_oen ? model(mem_addr) : 16'hDEAD;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  bank_cfg_t shadow [NB];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bank_cfg_t mk(int acp, int cah, int coh, int acc, int cos, int acs, bit wide, bit page);
    bank_cfg_t c;
    c.acp = 4'(acp); c.cah = 4'(cah); c.coh = 4'(coh); c.acc = 5'(acc);
    c.cos = 4'(cos); c.acs = 4'(acs); c.wide = wide; c.page = page;
    return c;
  endfunction

  task automatic set_cfg(int b, bank_cfg_t c);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 2'(b); cfg_word = c;
    @(negedge clk);
    cfg_wr = 1'b0;
    shadow[b] = c;
  endtask

  task automatic xfer(string name, int b, int off, bit wr, logic [DW-1:0] wd);
    bank_cfg_t c;
    bit pg;
    int beats, oecyc, e_cs, e_sel, e_cscnt, e_done, n, f_cs, f_sel, cs_cnt, sel_cnt;
    int doe_cnt, csbad, oth, dbad, rdybad, abad, rel, bi;
    logic [AW-1:0] base, ea;
    logic [63:0]   e_rd;
    logic [DW-1:0] e_dout, d;
    c      = shadow[b];
    pg     = c.page && !wr;
    beats  = pg ? NBEAT : 1;
    oecyc  = int'(c.acc) + 1 + (pg ? 3 * (int'(c.acp) + 1) : 0);
    e_cs   = int'(c.acs) + 1;
    e_sel  = int'(c.acs) + int'(c.cos) + 1;
    e_cscnt = int'(c.cos) + oecyc + int'(c.coh);
    e_done = int'(c.acs) + int'(c.cos) + oecyc + int'(c.coh) + int'(c.cah) + 1;
    base   = c.wide ? AW'(off >> 1) : AW'(off);
    e_dout = c.wide ? wd : {8'h00, wd[7:0]};
    e_rd   = '0;
    for (int k = 0; k < beats; k++) begin
      ea = {base[AW-1:2], 2'(base[1:0] + 2'(k))};
      d  = model(ea);
      e_rd[16*k +: 16] = c.wide ? d : {8'h00, d[7:0]};
    end
    f_cs = 0; f_sel = 0; cs_cnt = 0; sel_cnt = 0; doe_cnt = 0;
    csbad = 0; oth = 0; dbad = 0; rdybad = 0; abad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {2'(b), AW'(off)}; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    forever begin
      if (mem_csn != 4'hF) begin
        if (f_cs == 0) f_cs = n;
        cs_cnt++;
        if (mem_csn != ~(4'b0001 << b)) csbad++;
      end
      if (wr ? !mem_wen : !mem_oen) begin
        if (f_sel == 0) f_sel = n;
        sel_cnt++;
      end
      if (wr ? !mem_oen : !mem_wen) oth++;
      if (mem_doe) begin
        doe_cnt++;
        if (mem_dout !== e_dout) dbad++;
      end
      if (req_ready && !rsp_valid) rdybad++;
      if (n < e_sel) bi = 0;
      else begin
        rel = n - e_sel;
        bi = (rel < int'(c.acc) + 1) ? 0 : 1 + (rel - int'(c.acc) - 1) / (int'(c.acp) + 1);
        if (bi > beats - 1) bi = beats - 1;
      end
      ea = {base[AW-1:2], 2'(base[1:0] + 2'(bi))};
      if (!rsp_valid && mem_addr !== ea) abad++;
      if (rsp_valid || n >= 300) break;
      @(negedge clk);
      n++;
    end
    chk({name, " R3 chip select start"}, 64'(f_cs), 64'(e_cs));
    chk({name, " R4 strobe start"}, 64'(f_sel), 64'(e_sel));
    chk({name, " R4 R7 strobe length"}, 64'(sel_cnt), 64'(oecyc));
    chk({name, " R5 chip select length"}, 64'(cs_cnt), 64'(e_cscnt));
    chk({name, " R5 response cycle"}, 64'(n), 64'(e_done));
    chk({name, " R2 bank select"}, 64'(csbad), 64'd0);
    chk({name, " R11 other strobe idle"}, 64'(oth), 64'd0);
    chk({name, " R10 ready low while busy"}, 64'(rdybad), 64'd0);
    chk({name, " R6 R7 external address"}, 64'(abad), 64'd0);
    if (wr) begin
      chk({name, " R8 drive window"}, 64'(doe_cnt), 64'(oecyc + int'(c.coh)));
      chk({name, " R8 write data"}, 64'(dbad), 64'd0);
    end else begin
      chk({name, " R6 R7 read data"}, rsp_rdata, e_rd);
      chk({name, " R8 no drive on read"}, 64'(doe_cnt), 64'd0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready after reset", 64'(req_ready), 64'd1);
    chk("R1 chip selects idle", 64'(mem_csn), 64'hF);
    chk("R1 strobes idle", 64'({mem_oen, mem_wen}), 64'h3);
    chk("R1 no drive, no response", 64'({mem_doe, rsp_valid}), 64'h0);
  endtask

  task automatic t_default_bank();
    xfer("R9 default bank0 read", 0, 'h15, 1'b0, '0);
  endtask

  task automatic t_timed_read();
    set_cfg(1, mk(0, 2, 1, 4, 3, 2, 1'b1, 1'b0));
    xfer("R3 timed halfword read", 1, 'h2A, 1'b0, '0);
  endtask

  task automatic t_page_read();
    set_cfg(3, mk(9, 12, 1, 9, 1, 1, 1'b1, 1'b1));
    xfer("R7 page read wrap", 3, 'h106, 1'b0, '0);
  endtask

  task automatic t_byte_write();
    set_cfg(2, mk(5, 0, 2, 31, 0, 1, 1'b0, 1'b1));
    xfer("R8 byte write page ignored", 2, 'h0F3, 1'b1, 16'hBEEF);
  endtask

  task automatic t_wide_write();
    xfer("R8 halfword write", 1, 'h40, 1'b1, 16'h1234);
  endtask

  task automatic t_independent();
    xfer("R9 bank0 unchanged", 0, 'h7, 1'b0, '0);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_reset();
    t_default_bank();
    t_timed_read();
    t_page_read();
    t_byte_write();
    t_wide_write();
    t_independent();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule